// File: doc/BRIEF.md
# Serial Receive Queue with Head-Deferred Error Status

This block is the receive half of an asynchronous serial port. A bit-level receiver (not part of this block) hands it one assembled character at a time as a one-cycle strobe. The strobe comes with the received parity bit and the sampled stop bit. The block computes a parity-error tag and a framing-error tag for the character and stores both beside its byte in a four-entry queue. Software drains the queue through a read strobe. Status outputs report whether data is waiting, and whether an overrun, parity error or framing error has been seen.

Error reporting is tied to the queue head rather than to arrival time. A tagged character raises its flag only when it becomes the oldest entry. An overrun is recorded against the last character that was accepted. The overrun flag rises only once that character reaches the head, and every character that arrives before then is dropped. One write-one-to-clear strobe clears all three error flags. A carrier-detect input can also clear them, and empty the queue, when its auto-enable is on. A single registered interrupt combines data-ready and error conditions. A DMA-routing input suppresses the data-ready part of the interrupt.

Top module: `serial_rx_queue`

## Requirements
- R1: A character strobed into an empty queue sets `rx_full` at the same clock edge that samples the strobe.
- R2: Each `rd_en` with data held loads the oldest byte onto `rd_data` at that edge, in arrival order. `rx_full` falls at the edge that removes the last held byte.
- R3: A character carrying a parity or framing error is still stored, still sets `rx_full`, and is read back unchanged.
- R4: With `parity_en` = 1, a character has a parity error when `char_par` differs from XOR(`char_data`) XOR `parity_odd` (`parity_odd` = 0 selects even, 1 selects odd). With `parity_en` = 0, no parity error is recorded. `parity_err` rises one edge after the bad character becomes the oldest entry, and not before that.
- R5: `char_stop` = 0 marks a framing error. `frame_err` rises one edge after that character becomes the oldest entry.
- R6: A character arriving while four entries are held and no read occurs in the same cycle is dropped. `overrun` rises one edge after the last accepted character becomes the oldest entry.
- R7: From the dropped overrun character until `overrun` has risen, every strobed character is dropped, even when a read has freed room. Characters after that point are accepted again.
- R8: A one-cycle `err_clr` clears `overrun`, `parity_err` and `frame_err` together at the next edge and leaves the queued data untouched.
- R9: While `dcd_auto_en` = 1 and `dcd_n` = 1, the queue is emptied and all status flags are cleared. With `dcd_auto_en` = 0, `dcd_n` has no effect.
- R10: After synchronous reset, `rx_full`, `overrun`, `parity_err`, `frame_err` and `irq` are 0.
- R11: `irq` is a registered output equal to `irq_en` AND ((data held AND NOT `dma_route`) OR any error flag), using the values settled at the same edge. With `irq_en` = 0 it stays 0.
- R12: `rd_en` on an empty queue changes neither `rd_data` nor any status output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_valid | input | 1 | One-cycle strobe: a character has been assembled |
| char_data | input | 8 | Assembled character |
| char_par | input | 1 | Received parity bit |
| char_stop | input | 1 | Sampled stop bit (0 = space) |
| parity_en | input | 1 | Enable parity checking |
| parity_odd | input | 1 | 0 = even parity, 1 = odd parity |
| rd_en | input | 1 | Read strobe for the data register |
| rd_data | output | 8 | Last byte read from the queue |
| err_clr | input | 1 | Write-one strobe clearing all error flags |
| irq_en | input | 1 | Receive interrupt enable |
| dma_route | input | 1 | A DMA channel services this receiver; masks data-ready interrupt |
| dcd_n | input | 1 | Carrier detect, high when negated |
| dcd_auto_en | input | 1 | Let negated carrier detect clear the receiver |
| rx_full | output | 1 | At least one byte is waiting |
| overrun | output | 1 | Overrun flag |
| parity_err | output | 1 | Parity error flag |
| frame_err | output | 1 | Framing error flag |
| irq | output | 1 | Interrupt request |

## Verification
`rx_full`, `irq` and `rd_data` change at the edge that samples the strobe that causes them. The bench therefore reads them 1 ns after that edge. Error flags need one more edge once their character is the oldest entry. The checks first confirm that a flag is still low in the cycle the character reaches the head, and then advance exactly one clock before expecting it high. For an overrun, each of the three reads is stepped individually, and `overrun` is checked low after the third read and high one edge later.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic perr;
    logic ferr;
  } rx_tag_t;
endpackage

// File: rtl/rxq_tagger.sv
module rxq_tagger
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              par_bit,
  input  logic              stop_bit,
  input  logic              parity_en,
  input  logic              parity_odd,
  output rx_tag_t           tag
);
  logic want_par;

  always_comb begin
    want_par = (^data) ^ parity_odd;
    tag.perr = parity_en & (par_bit != want_par);
    tag.ferr = ~stop_bit;
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] wr_data,
  input  rx_tag_t           wr_tag,
  output logic [DATA_W-1:0] rd_q,
  output rx_tag_t           head_tag,
  output logic [PTR_W-1:0]  head_idx,
  output logic [PTR_W-1:0]  last_idx,
  output logic              full,
  output logic              nonempty,
  output logic              pop_ok,
  output logic              ne_nxt,
  output logic              ne_q
);
  logic [DATA_W-1:0] mem [DEPTH];
  rx_tag_t           tag_mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt, cnt_nxt;

  always_comb begin
    nonempty = (cnt != '0);
    full     = (cnt == CNT_W'(DEPTH));
    pop_ok   = rd_req & nonempty & ~flush;
    cnt_nxt  = flush ? '0 : cnt + CNT_W'(push) - CNT_W'(pop_ok);
    ne_nxt   = (cnt_nxt != '0);
    head_tag = tag_mem[rd_ptr];
    head_idx = rd_ptr;
    last_idx = wr_ptr - PTR_W'(1);
  end

  // data array: write port and registered read port, RAM friendly
  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_q <= '0;
    else if (pop_ok) rd_q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (push && !flush) tag_mem[wr_ptr] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ne_q   <= 1'b0;
    end else begin
      if (push)   wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop_ok) rd_ptr <= rd_ptr + PTR_W'(1);
      cnt  <= cnt_nxt;
      ne_q <= ne_nxt;
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));

  // R2
  ne_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ne_q) |-> ($past(pop_ok) || $past(flush)));
endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             err_clr,
  input  logic             pop_ok,
  input  logic             nonempty,
  input  logic             ne_nxt,
  input  rx_tag_t          head_tag,
  input  logic [PTR_W-1:0] head_idx,
  input  logic [PTR_W-1:0] last_idx,
  input  logic             ovr_hit,
  input  logic             irq_en,
  input  logic             dma_route,
  output logic             ovr_pend,
  output logic             ovr_q,
  output logic             pe_q,
  output logic             fe_q,
  output logic             irq_q
);
  logic             seen_q;
  logic [PTR_W-1:0] ovr_idx_q;
  logic             pe_set, fe_set, ovr_set;
  logic             pe_n, fe_n, ovr_n;

  always_comb begin
    pe_set  = nonempty & ~seen_q & head_tag.perr;
    fe_set  = nonempty & ~seen_q & head_tag.ferr;
    ovr_set = ovr_pend & nonempty & (head_idx == ovr_idx_q);
    pe_n    = ~flush & ((pe_q  & ~err_clr) | pe_set);
    fe_n    = ~flush & ((fe_q  & ~err_clr) | fe_set);
    ovr_n   = ~flush & ((ovr_q & ~err_clr) | ovr_set);
  end

  always_ff @(posedge clk) begin
    if (flush) begin
      seen_q    <= 1'b0;
      ovr_pend  <= 1'b0;
      ovr_idx_q <= '0;
      ovr_q     <= 1'b0;
      pe_q      <= 1'b0;
      fe_q      <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (pop_ok)        seen_q <= 1'b0;
      else if (nonempty) seen_q <= 1'b1;
      if (ovr_hit) begin
        ovr_pend  <= 1'b1;
        ovr_idx_q <= last_idx;
      end else if (ovr_set) begin
        ovr_pend  <= 1'b0;
      end
      ovr_q <= ovr_n;
      pe_q  <= pe_n;
      fe_q  <= fe_n;
      irq_q <= irq_en & ((ne_nxt & ~dma_route) | ovr_n | pe_n | fe_n);
    end
  end

  // R6
  ovr_from_pend_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_q) |-> $past(ovr_pend));

  // R4
  pe_needs_head_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pe_q) |-> $past(nonempty));

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !pe_set && !fe_set && !ovr_set) |=> !(ovr_q || pe_q || fe_q));
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              char_valid,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_par,
  input  logic              char_stop,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              err_clr,
  input  logic              irq_en,
  input  logic              dma_route,
  input  logic              dcd_n,
  input  logic              dcd_auto_en,
  output logic              rx_full,
  output logic              overrun,
  output logic              parity_err,
  output logic              frame_err,
  output logic              irq
);
  rx_tag_t          new_tag, head_tag;
  logic [PTR_W-1:0] head_idx, last_idx;
  logic             full, nonempty, pop_ok, ne_nxt, ne_q;
  logic             ovr_pend, carrier_clr, flush, take, ovr_hit;

  always_comb begin
    carrier_clr = dcd_auto_en & dcd_n;
    flush       = rst | carrier_clr;
    take        = char_valid & ~flush & ~ovr_pend & (~full | pop_ok);
    ovr_hit     = char_valid & ~flush & ~ovr_pend & full & ~pop_ok;
  end

  rxq_tagger #(.DATA_W(DATA_W)) u_tag (
    .data(char_data), .par_bit(char_par), .stop_bit(char_stop),
    .parity_en(parity_en), .parity_odd(parity_odd), .tag(new_tag)
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .flush(flush), .push(take), .rd_req(rd_en),
    .wr_data(char_data), .wr_tag(new_tag), .rd_q(rd_data),
    .head_tag(head_tag), .head_idx(head_idx), .last_idx(last_idx),
    .full(full), .nonempty(nonempty), .pop_ok(pop_ok),
    .ne_nxt(ne_nxt), .ne_q(ne_q)
  );

  rxq_status #(.DEPTH(DEPTH)) u_stat (
    .clk(clk), .rst(rst), .flush(flush), .err_clr(err_clr),
    .pop_ok(pop_ok), .nonempty(nonempty), .ne_nxt(ne_nxt),
    .head_tag(head_tag), .head_idx(head_idx), .last_idx(last_idx),
    .ovr_hit(ovr_hit), .irq_en(irq_en), .dma_route(dma_route),
    .ovr_pend(ovr_pend), .ovr_q(overrun), .pe_q(parity_err),
    .fe_q(frame_err), .irq_q(irq)
  );

  assign rx_full = ne_q;

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);

  // R1
  full_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full) |-> $past(char_valid));

  // R9
  carrier_chk: assert property (@(posedge clk) disable iff (rst)
    carrier_clr |=> !(rx_full || overrun || parity_err || frame_err));
endmodule

// File: tb/tb_serial_rx_queue.sv
module tb_serial_rx_queue;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       char_valid = 1'b0;
  logic [7:0] char_data = '0;
  logic       char_par = 1'b0, char_stop = 1'b1;
  logic       parity_en = 1'b0, parity_odd = 1'b0;
  logic       rd_en = 1'b0, err_clr = 1'b0;
  logic       irq_en = 1'b1, dma_route = 1'b0;
  logic       dcd_n = 1'b0, dcd_auto_en = 1'b0;
  logic [7:0] rd_data;
  logic       rx_full, overrun, parity_err, frame_err, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  logic [7:0] last_rd = 8'h00;

  always #2 clk = ~clk;

  serial_rx_queue dut (
    .clk(clk), .rst(rst), .char_valid(char_valid), .char_data(char_data),
    .char_par(char_par), .char_stop(char_stop), .parity_en(parity_en),
    .parity_odd(parity_odd), .rd_en(rd_en), .rd_data(rd_data),
    .err_clr(err_clr), .irq_en(irq_en), .dma_route(dma_route),
    .dcd_n(dcd_n), .dcd_auto_en(dcd_auto_en), .rx_full(rx_full),
    .overrun(overrun), .parity_err(parity_err), .frame_err(frame_err),
    .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic good_par(logic [7:0] d);
    return (^d) ^ parity_odd;
  endfunction

  // driver: strobe a character, record it in the scoreboard if it should land
  task automatic send(logic [7:0] d, logic par, logic stop, bit accepted);
    char_valid = 1'b1; char_data = d; char_par = par; char_stop = stop;
    tick();
    char_valid = 1'b0;
    if (accepted) exp_q.push_back(d);
  endtask

  // monitor: read one entry and compare against the oldest expected byte
  task automatic rd(string req);
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    if (exp_q.size() != 0) last_rd = exp_q.pop_front();
    chk(req, rd_data, last_rd);
  endtask

  task automatic clear_errs();
    err_clr = 1'b1;
    tick();
    err_clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    tick();
    // R10 reset state
    chk("R10 rx_full", rx_full, 0);
    chk("R10 flags", {overrun, parity_err, frame_err}, 0);
    chk("R10 irq", irq, 0);

    // R1 / R2 / R11 basic path
    send(8'h5A, good_par(8'h5A), 1'b1, 1);
    chk("R1 rx_full set", rx_full, 1);
    chk("R11 irq data ready", irq, 1);
    rd("R2 read 5A");
    chk("R2 rx_full clear", rx_full, 0);
    chk("R11 irq drop", irq, 0);

    // R12 read on empty
    rd("R12 rd_data held");
    chk("R12 status unchanged", {rx_full, overrun, parity_err, frame_err}, 0);

    // R11 DMA routing masks data-ready
    dma_route = 1'b1;
    send(8'h11, good_par(8'h11), 1'b1, 1);
    chk("R11 dma mask irq", irq, 0);
    chk("R1 rx_full dma", rx_full, 1);
    rd("R2 read 11");

    // R4 parity, even, deferred to head; R11 errors bypass mask
    parity_en = 1'b1; parity_odd = 1'b0;
    send(8'h31, good_par(8'h31), 1'b1, 1);
    send(8'h32, ~good_par(8'h32), 1'b1, 1);
    chk("R4 not at head", parity_err, 0);
    rd("R2 read 31");
    chk("R4 head this edge, flag pending", parity_err, 0);
    tick();
    chk("R4 parity flag", parity_err, 1);
    chk("R11 error irq despite dma", irq, 1);
    rd("R3 errored byte 32 stored");
    clear_errs();
    chk("R8 parity cleared", parity_err, 0);
    dma_route = 1'b0;

    // R4 parity disabled
    parity_en = 1'b0;
    send(8'h33, ~good_par(8'h33), 1'b1, 1);
    tick();
    chk("R4 disabled no flag", parity_err, 0);
    rd("R2 read 33");

    // R4 odd parity
    parity_en = 1'b1; parity_odd = 1'b1;
    send(8'h07, (^8'h07), 1'b1, 1);
    tick();
    chk("R4 odd mismatch flag", parity_err, 1);
    rd("R3 read 07");
    clear_errs();
    send(8'h07, good_par(8'h07), 1'b1, 1);
    tick();
    chk("R4 odd match no flag", parity_err, 0);
    rd("R2 read 07 again");
    parity_en = 1'b0; parity_odd = 1'b0;

    // R5 framing
    send(8'h66, 1'b0, 1'b0, 1);
    chk("R3 framed byte sets full", rx_full, 1);
    tick();
    chk("R5 frame flag", frame_err, 1);
    rd("R3 read 66");
    clear_errs();
    chk("R8 frame cleared", frame_err, 0);

    // R6 / R7 overrun
    send(8'h01, 1'b0, 1'b1, 1);
    send(8'h02, 1'b0, 1'b1, 1);
    send(8'h03, 1'b0, 1'b1, 1);
    send(8'h04, 1'b0, 1'b1, 1);
    send(8'h05, 1'b0, 1'b1, 0);
    chk("R6 overrun deferred", overrun, 0);
    rd("R2 read 01");
    send(8'h88, 1'b0, 1'b1, 0);
    rd("R2 read 02");
    dma_route = 1'b1;
    rd("R2 read 03");
    chk("R6 flag one edge after head", overrun, 0);
    tick();
    chk("R6 overrun set", overrun, 1);
    chk("R11 overrun irq", irq, 1);
    send(8'h07, 1'b0, 1'b1, 1);
    rd("R7 read 04");
    rd("R7 read 07, dropped ones absent");
    chk("R7 queue empty", rx_full, 0);
    clear_errs();
    chk("R8 overrun cleared", overrun, 0);
    dma_route = 1'b0;

    // R8 err_clr keeps data
    send(8'h21, 1'b0, 1'b0, 1);
    tick();
    clear_errs();
    chk("R8 data kept", rx_full, 1);
    rd("R8 read 21");

    // R9 carrier detect
    send(8'h44, 1'b0, 1'b0, 1);
    send(8'h45, 1'b0, 1'b1, 1);
    tick();
    chk("R5 frame flag 44", frame_err, 1);
    dcd_n = 1'b1; dcd_auto_en = 1'b0;
    tick();
    chk("R9 no auto no effect", {rx_full, frame_err}, 2'b11);
    dcd_auto_en = 1'b1;
    tick();
    chk("R9 carrier flush", {rx_full, overrun, parity_err, frame_err}, 0);
    exp_q.delete();
    dcd_n = 1'b0;
    tick();
    send(8'h46, 1'b0, 1'b1, 1);
    rd("R9 read after flush");
    dcd_auto_en = 1'b0;

    // R11 enable off
    irq_en = 1'b0;
    send(8'h50, 1'b0, 1'b1, 1);
    chk("R11 irq disabled", irq, 0);
    rd("R2 read 50");

    tick();
    finish_run();
  end
endmodule